// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block paces the slow modulation units of a retro sound generator. It advances once per CPU clock and produces two single-cycle strobes: a quarter-frame tick that drives the envelope and linear-counter units, and a half-frame tick that drives the length and sweep units. Two sequences are available. The four-step sequence raises a frame interrupt at the end of every frame. The five-step sequence is longer, has one silent step and never raises the interrupt.

Software reprograms the block through one control write. Bit 7 selects the five-step sequence and bit 6 blocks the frame interrupt. The new settings do not apply at once. They are held as pending values and applied three or four cycles later; the delay depends on the parity of the current cycle. On the cycle the new settings apply, the step counter restarts from zero. If the new sequence is the five-step one, both strobes fire in that same cycle. A status-read acknowledge clears the frame interrupt. The interrupt output is also ORed with an external sample-channel interrupt.

Top module: `frame_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `qtr_stb`, `half_stb` and `irq` are low (with `ext_irq` low). Reset selects the four-step sequence with the interrupt not blocked and the step counter at zero.
- R2: In the four-step sequence, counting clock edges from the last counter clear, `qtr_stb` pulses at edges 7457, 14913, 22371 and 29829 and `half_stb` pulses at 14913 and 29829. The counter then wraps, so the frame repeats every 29829 edges.
- R3: In the five-step sequence, `qtr_stb` pulses at edges 7457, 14913, 22371 and 37281 and `half_stb` pulses at 14913 and 37281. Nothing fires at 29829, the frame repeats every 37281 edges, and the frame interrupt is never set.
- R4: A control write (`ctl_wr` high at a clock edge) stores `ctl_data[7]` (1 = five-step) and `ctl_data[6]` (1 = interrupt blocked) as pending values. A parity bit starts at 0 after reset and toggles at every edge. A write taken at edge W applies at edge W+4 when the parity before edge W is 1 (W even, counting edges from reset release), and at edge W+3 otherwise. A later write restarts the delay.
- R5: At the edge where pending values apply, the step counter is cleared and the normal step is skipped. If the new sequence is five-step, `qtr_stb` and `half_stb` both pulse in that cycle; if it is four-step, neither pulses.
- R6: In the four-step sequence with the interrupt not blocked, the last step sets a pending frame interrupt. The interrupt stays set until it is cleared.
- R7: `stat_ack` high at an edge clears the pending frame interrupt. A clear takes priority over a set at the same edge.
- R8: A control write with `ctl_data[6]` = 1 clears the pending frame interrupt at the write edge itself, before the delay.
- R9: `irq` = (pending frame interrupt AND NOT applied block bit) OR `ext_irq`.
- R10: Each strobe is high for exactly one cycle per event, and `half_stb` is never high without `qtr_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; one step per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control write data (bit 7 five-step, bit 6 block interrupt) |
| stat_ack | input | 1 | Status-read acknowledge; clears the frame interrupt |
| ext_irq | input | 1 | External sample-channel interrupt, ORed into `irq` |
| qtr_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong step counter or a wrong sequence selection moves a strobe edge. That shows at the ports within one frame, up to 37281 cycles later. An error in the delay or the parity moves the restart by one cycle. It is caught at the cycle the pending setting should apply, because a five-step restart fires both strobes right there, and at every later step edge, which all shift by the same amount. A stuck or mis-cleared interrupt flag shows on `irq` in the cycle after the acknowledge or the blocking write.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef struct packed {
    logic qtr;
    logic half;
    logic irq;
    logic wrap;
  } step_evt_t;

  // Delay loaded by a control write, selected by the current parity.
  function automatic logic [2:0] reload_delay(input logic parity_odd);
    return parity_odd ? 3'd4 : 3'd3;
  endfunction

  // Event decode for the step number reached on this edge.
  function automatic step_evt_t decode_step(
    input logic        five,
    input int unsigned n,
    input int unsigned s1,
    input int unsigned s2,
    input int unsigned s3,
    input int unsigned s4,
    input int unsigned s5
  );
    step_evt_t e;
    e = '0;
    if (!five) begin
      e.qtr  = (n == s1) || (n == s2) || (n == s3) || (n == s4);
      e.half = (n == s2) || (n == s4);
      e.irq  = (n == s4);
      e.wrap = (n == s4);
    end else begin
      e.qtr  = (n == s1) || (n == s2) || (n == s3) || (n == s5);
      e.half = (n == s2) || (n == s5);
      e.irq  = 1'b0;
      e.wrap = (n == s5);
    end
    return e;
  endfunction

endpackage

// File: rtl/frame_ctl.sv
module frame_ctl #(
  parameter int MODE_BIT = 7,
  parameter int INH_BIT  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       commit,
  output logic       commit_five,
  output logic       mode_five,
  output logic       inhibit,
  output logic       pend_active
);
  import frame_seq_pkg::*;

  logic       parity_q;
  logic       pend_q;
  logic [2:0] dly_q;
  logic       pend_five_q;
  logic       pend_inh_q;
  logic       five_q;
  logic       inh_q;

  assign commit      = pend_q && (dly_q == 3'd1) && !wr;
  assign commit_five = pend_five_q;
  assign mode_five   = five_q;
  assign inhibit     = inh_q;
  assign pend_active = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity_q    <= 1'b0;
      pend_q      <= 1'b0;
      dly_q       <= 3'd0;
      pend_five_q <= 1'b0;
      pend_inh_q  <= 1'b0;
      five_q      <= 1'b0;
      inh_q       <= 1'b0;
    end else begin
      parity_q <= ~parity_q;
      if (wr) begin
        pend_q      <= 1'b1;
        dly_q       <= reload_delay(parity_q);
        pend_five_q <= wdata[MODE_BIT];
        pend_inh_q  <= wdata[INH_BIT];
      end else if (pend_q) begin
        if (dly_q == 3'd1) begin
          pend_q <= 1'b0;
          dly_q  <= 3'd0;
          five_q <= pend_five_q;
          inh_q  <= pend_inh_q;
        end else begin
          dly_q <= dly_q - 3'd1;
        end
      end
    end
  end

endmodule

// File: rtl/frame_steps.sv
module frame_steps #(
  parameter int unsigned STEP1 = 7457,
  parameter int unsigned STEP2 = 14913,
  parameter int unsigned STEP3 = 22371,
  parameter int unsigned STEP4 = 29829,
  parameter int unsigned STEP5 = 37281,
  localparam int CW = $clog2(STEP5 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          commit_five,
  input  logic          mode_five,
  output logic          evt_qtr,
  output logic          evt_half,
  output logic          evt_irq,
  output logic [CW-1:0] cnt
);
  import frame_seq_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nxt;
  step_evt_t     ev;

  assign nxt = cnt_q + 1'b1;
  assign cnt = cnt_q;

  always_comb begin
    ev = decode_step(mode_five, 32'(nxt), STEP1, STEP2, STEP3, STEP4, STEP5);
    if (commit) begin
      evt_qtr  = commit_five;
      evt_half = commit_five;
      evt_irq  = 1'b0;
    end else begin
      evt_qtr  = ev.qtr;
      evt_half = ev.half;
      evt_irq  = ev.irq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (commit || ev.wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= nxt;
    end
  end

endmodule

// File: rtl/frame_irq.sv
module frame_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic inhibit,
  input  logic ext_irq,
  output logic pend,
  output logic irq
);
  logic pend_q;

  assign pend = pend_q;
  assign irq  = (pend_q && !inhibit) || ext_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (clr_evt) begin
      pend_q <= 1'b0;
    end else if (set_evt && !inhibit) begin
      pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top #(
  parameter int unsigned STEP1    = 7457,
  parameter int unsigned STEP2    = 14913,
  parameter int unsigned STEP3    = 22371,
  parameter int unsigned STEP4    = 29829,
  parameter int unsigned STEP5    = 37281,
  parameter int          MODE_BIT = 7,
  parameter int          INH_BIT  = 6,
  localparam int CW = $clog2(STEP5 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       stat_ack,
  input  logic       ext_irq,
  output logic       qtr_stb,
  output logic       half_stb,
  output logic       irq
);
  // Internal events, named for the bound checker.
  logic          commit;
  logic          commit_five;
  logic          mode_five;
  logic          inhibit;
  logic          pend_active;
  logic          evt_qtr;
  logic          evt_half;
  logic          evt_irq;
  logic [CW-1:0] step_cnt;
  logic          irq_pend;
  logic          irq_clr;

  assign irq_clr = stat_ack || (ctl_wr && ctl_data[INH_BIT]);

  frame_ctl #(.MODE_BIT(MODE_BIT), .INH_BIT(INH_BIT)) ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (ctl_wr),
    .wdata       (ctl_data),
    .commit      (commit),
    .commit_five (commit_five),
    .mode_five   (mode_five),
    .inhibit     (inhibit),
    .pend_active (pend_active)
  );

  frame_steps #(
    .STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3), .STEP4(STEP4), .STEP5(STEP5)
  ) steps_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_five (commit_five),
    .mode_five   (mode_five),
    .evt_qtr     (evt_qtr),
    .evt_half    (evt_half),
    .evt_irq     (evt_irq),
    .cnt         (step_cnt)
  );

  frame_irq irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (evt_irq),
    .clr_evt (irq_clr),
    .inhibit (inhibit),
    .ext_irq (ext_irq),
    .pend    (irq_pend),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qtr_stb  <= 1'b0;
      half_stb <= 1'b0;
    end else begin
      qtr_stb  <= evt_qtr;
      half_stb <= evt_half;
    end
  end

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic          stat_ack,
  input logic          ext_irq,
  input logic          qtr_stb,
  input logic          half_stb,
  input logic          irq,
  input logic          commit,
  input logic          commit_five,
  input logic          mode_five,
  input logic          inhibit,
  input logic          pend_active,
  input logic          evt_irq,
  input logic [CW-1:0] step_cnt,
  input logic          irq_pend
);
  // R10: half strobe only together with quarter strobe
  a_r10_half_with_qtr: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb |-> qtr_stb);

  // R3: five-step sequence never raises the frame interrupt
  a_r3_five_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_five && !commit) |-> !evt_irq);

  // R4: a write leaves settings pending
  a_r4_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> pend_active);

  // R5: applying settings clears the counter
  a_r5_commit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (step_cnt == '0));

  // R5: five-step restart fires both strobes
  a_r5_five_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_five) |=> (qtr_stb && half_stb));

  // R6: last four-step step sets the interrupt
  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_irq && !inhibit && !stat_ack && !(ctl_wr && ctl_data[6])) |=> irq_pend);

  // R7: acknowledge clears the interrupt
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ack |=> !irq_pend);

  // R8: blocking write clears the interrupt at once
  a_r8_block_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[6]) |=> !irq_pend);

  // R9: blocked and no external source means no request
  a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !ext_irq) |-> !irq);

endmodule

bind frame_seq_top frame_seq_chk #(.CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr      (ctl_wr),
  .ctl_data    (ctl_data),
  .stat_ack    (stat_ack),
  .ext_irq     (ext_irq),
  .qtr_stb     (qtr_stb),
  .half_stb    (half_stb),
  .irq         (irq),
  .commit      (commit),
  .commit_five (commit_five),
  .mode_five   (mode_five),
  .inhibit     (inhibit),
  .pend_active (pend_active),
  .evt_irq     (evt_irq),
  .step_cnt    (step_cnt),
  .irq_pend    (irq_pend)
);

// File: tb/frame_seq_top_tb_top.sv
`timescale 1ns/1ps
module frame_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic       stat_ack = 1'b0;
  logic       ext_irq = 1'b0;
  logic       qtr_stb;
  logic       half_stb;
  logic       irq;

  always #5 clk = ~clk;

  frame_seq_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .stat_ack (stat_ack),
    .ext_irq  (ext_irq),
    .qtr_stb  (qtr_stb),
    .half_stb (half_stb),
    .irq      (irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ecount = 0;

  typedef struct packed {
    logic [19:0] at;
    logic [1:0]  op;   // 0 check, 1 control write, 2 acknowledge
    logic [7:0]  dat;
    logic        q;
    logic        h;
    logic        i;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{20'd7457,   2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 first quarter
    '{20'd14913,  2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 quarter+half
    '{20'd22371,  2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 quarter
    '{20'd29829,  2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 last step sets irq
    '{20'd37286,  2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 wrap, irq held (R6)
    '{20'd37290,  2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ack clears
    '{20'd40000,  2'd1, 8'hC0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 write, W even -> 4
    '{20'd40004,  2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 five-step restart
    '{20'd47461,  2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{20'd54917,  2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
    '{20'd62375,  2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{20'd69833,  2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 silent step
    '{20'd77285,  2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 last step, no irq
    '{20'd77301,  2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 write, W odd -> 3
    '{20'd77304,  2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 four-step restart
    '{20'd84761,  2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 delay of 3 applied
    '{20'd107133, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd6},  // R6
    '{20'd107140, 2'd1, 8'h40, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 blocking write clears
    '{20'd136973, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd9}   // R9 blocked: no irq
  };

  task automatic chk(input string what, input int req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s at edge %0d: actual %b expected %b", req, what, ecount, act, exp);
    end
  endtask

  // Advance to the falling edge after clock edge n (counted from reset release).
  task automatic goto(input int n);
    while (ecount < n) begin
      @(posedge clk);
      ecount++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired at edge %0d: actual running expected done", ecount);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("qtr in reset", 1, qtr_stb, 1'b0);
    chk("half in reset", 1, half_stb, 1'b0);
    chk("irq in reset", 1, irq, 1'b0);
    rst_n = 1'b1;
    goto(1);
    chk("qtr after reset", 1, qtr_stb, 1'b0);
    chk("irq after reset", 1, irq, 1'b0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      if (v.op == 2'd0) begin
        goto(int'(v.at) - 1);
        chk("qtr before step", 10, qtr_stb, 1'b0);
        chk("half before step", 10, half_stb, 1'b0);
        goto(int'(v.at));
        chk("qtr", int'(v.req), qtr_stb, v.q);
        chk("half", int'(v.req), half_stb, v.h);
        chk("irq", int'(v.req), irq, v.i);
        goto(int'(v.at) + 1);
        chk("qtr one cycle", 10, qtr_stb, 1'b0);
        chk("half one cycle", 10, half_stb, 1'b0);
      end else begin
        goto(int'(v.at) - 1);
        if (v.op == 2'd1) begin
          ctl_wr = 1'b1;
          ctl_data = v.dat;
        end else begin
          stat_ack = 1'b1;
        end
        goto(int'(v.at));
        ctl_wr = 1'b0;
        ctl_data = 8'h00;
        stat_ack = 1'b0;
        chk("irq after op", int'(v.req), irq, v.i);
      end
    end

    // R9: external source passes through while frame interrupt is blocked
    goto(136980);
    ext_irq = 1'b1;
    #1;
    chk("irq from external", 9, irq, 1'b1);
    goto(136981);
    ext_irq = 1'b0;
    #1;
    chk("irq external released", 9, irq, 1'b0);

    // R1: reset mid-frame returns the four-step default
    rst_n = 1'b0;
    goto(136983);
    rst_n = 1'b1;
    ecount = 0;
    goto(7457);
    chk("qtr after re-reset", 1, qtr_stb, 1'b1);
    chk("half after re-reset", 1, half_stb, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule